// File: doc/BRIEF.md
# Push-Button Reset Request Filter

This block turns an active-low manual reset button into a clean, level-type reset request for a downstream reset generator. The raw button level is idle high and may bounce on both press and release. The block samples it through a synchroniser. It accepts a press only after the synchronised level has stayed low without a break for a programmable number of millisecond ticks. While the press is accepted, the request stays asserted.

Release is filtered in the same way. The request drops only after the synchronised level has stayed high without a break for a programmable number of ticks. Contact chatter at release therefore does not cut the request short or split it. A low pulse that lasts less than one tick period can meet at most one tick, so it never produces a request when the press count is at least two. A low lasting twenty tick periods always produces one. With the default press count of 4, detection latency is about 4 ms. Stretching reset after the request ends is handled by the reset generator.

The millisecond tick is a one-cycle enable from a shared timebase. Counting advances only on cycles where it is high.

Top module: `mr_debounce`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mr_req` is 0 on the following cycle. The synchroniser also returns to the idle-high level.
- R2: A low on `btn_n_raw` that is seen by fewer than PRESS_TICKS ticks never asserts `mr_req`. A low shorter than one tick period is therefore always ignored when PRESS_TICKS is at least 2.
- R3: The synchroniser delays `btn_n_raw` by two clock edges. Once the synchronised level is 0 on the cycles of PRESS_TICKS consecutive counted ticks, `mr_req` goes to 1 on the clock edge that samples the last of those ticks.
- R4: During a pending press, any cycle in which the synchronised level is 1 clears the press count, so counting starts again from zero.
- R5: While the button stays pressed, `mr_req` stays 1 no matter how many ticks pass.
- R6: `mr_req` returns to 0 on the edge that samples the RELEASE_TICKS-th consecutive tick with the synchronised level at 1. Any low seen during the release count restarts that count.
- R7: Cycles with `ms_tick` at 0 do not advance either count, and `mr_req` changes only on an edge that samples `ms_tick` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond enable |
| btn_n_raw | input | 1 | Raw button level, low when pressed |
| mr_req | output | 1 | Manual reset request, high while a press is recognised |

## Verification
The bench aims at the edges of both count windows.

- A glitch shorter than one tick is applied. A design that counts cycles instead of ticks, or that latches on the first low, would raise a request here.
- A press is broken by a single high gap. A design that does not clear the count would accept the two short halves as one press.
- A release bounces during its count. A design that does not restart the release count would drop the request early.
- Ticks are pulsed by hand, one at a time. This pins the exact tick at which the request rises and falls, so an off-by-one limit or a missing synchroniser stage shows as a one-tick shift.
- A long low is applied with no ticks at all. This exposes any counting that ignores the enable.

// File: rtl/mr_debounce_pkg.sv
// Shared types and helpers for the push-button reset request filter.
package mr_debounce_pkg;

    // Filter state: waiting for a press, or holding an accepted press.
    typedef enum logic {
        MR_IDLE = 1'b0,
        MR_HELD = 1'b1
    } mr_state_e;

    // Width of a counter that runs 0 .. limit-1, never less than one bit.
    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/mr_sync.sv
// Multi-stage synchroniser for an asynchronous level.
// Assumes STAGES >= 2. On reset every stage is loaded with RESET_VAL,
// so the output starts at the idle level of the input.
module mr_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mr_run_counter.sv
// Counts ticks during which a level keeps matching a target.
// A cycle without a match clears the count. A tick at limit_m1 raises
// done for that cycle and wraps the count to zero.
// Assumes limit_m1 never exceeds the counter range.
module mr_run_counter #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level,
    input  logic          target,
    input  logic          tick,
    input  logic [CW-1:0] limit_m1,
    output logic [CW-1:0] count,
    output logic          done
);
    logic match;

    // Decide whether this cycle ends a complete run.
    always_comb begin
        match = (level == target);
        done  = match && tick && (count == limit_m1);
    end

    // Advance on matching ticks, clear on any mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!match || done) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/mr_state.sv
// Two-state holder for the accepted press.
// It toggles between idle and held on each completed run, and it tells the
// counter which level and which limit to look for next.
module mr_state
    import mr_debounce_pkg::*;
#(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_done,
    input  logic [CW-1:0] press_m1,
    input  logic [CW-1:0] release_m1,
    output logic          want_level,
    output logic [CW-1:0] want_m1,
    output logic          req
);
    mr_state_e state_q;

    // Flip state whenever the current run completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MR_IDLE;
        end else if (run_done) begin
            state_q <= (state_q == MR_IDLE) ? MR_HELD : MR_IDLE;
        end
    end

    // Select the level and run length the counter must see next.
    always_comb begin
        want_level = (state_q == MR_HELD);
        want_m1    = (state_q == MR_HELD) ? release_m1 : press_m1;
        req        = (state_q == MR_HELD);
    end
endmodule

// File: rtl/mr_debounce.sv
// Push-button reset request filter (top).
// It synchronises an active-low button and asserts mr_req after
// PRESS_TICKS clean low ticks. It drops mr_req after RELEASE_TICKS clean
// high ticks. Assumes ms_tick is a single-cycle enable and that both
// tick counts are at least 1.
module mr_debounce
    import mr_debounce_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned PRESS_TICKS   = 4,
    parameter int unsigned RELEASE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic btn_n_raw,
    output logic mr_req
);
    localparam int unsigned MAX_TICKS = (PRESS_TICKS > RELEASE_TICKS) ? PRESS_TICKS : RELEASE_TICKS;
    localparam int unsigned CW        = cnt_width(MAX_TICKS);
    localparam logic [CW-1:0] PRESS_M1   = CW'(PRESS_TICKS - 1);
    localparam logic [CW-1:0] RELEASE_M1 = CW'(RELEASE_TICKS - 1);

    logic          btn_sync;
    logic [CW-1:0] run_cnt;
    logic          run_done;
    logic          want_level;
    logic [CW-1:0] want_m1;

    mr_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (btn_n_raw),
        .dout  (btn_sync)
    );

    mr_run_counter #(
        .CW (CW)
    ) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (btn_sync),
        .target   (want_level),
        .tick     (ms_tick),
        .limit_m1 (want_m1),
        .count    (run_cnt),
        .done     (run_done)
    );

    mr_state #(
        .CW (CW)
    ) i_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_done   (run_done),
        .press_m1   (PRESS_M1),
        .release_m1 (RELEASE_M1),
        .want_level (want_level),
        .want_m1    (want_m1),
        .req        (mr_req)
    );
endmodule

// File: rtl/mr_debounce_chk.sv
// Property checker for mr_debounce, attached by bind.
// It observes the ports plus the synchronised level and the run count.
module mr_debounce_chk #(
    parameter int unsigned MAX_TICKS = 4,
    parameter int unsigned CW        = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ms_tick,
    input logic          btn_sync,
    input logic [CW-1:0] run_cnt,
    input logic          mr_req
);
    // R1: reset clears the request
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> !mr_req);

    // R2: the run count stays inside its window
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(run_cnt) < MAX_TICKS);

    // R3: a request only rises after a low synchronised level
    a_r3_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_req) |-> !$past(btn_sync));

    // R4: a high sample during a pending press clears the count
    a_r4_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mr_req) && $past(btn_sync) && !mr_req) |-> (run_cnt == '0));

    // R6: a request only falls after a high synchronised level
    a_r6_fall_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mr_req) |-> $past(btn_sync));

    // R7: the request moves only on a tick
    a_r7_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mr_req) |-> $past(ms_tick));
endmodule

bind mr_debounce mr_debounce_chk #(
    .MAX_TICKS (MAX_TICKS),
    .CW        (CW)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick),
    .btn_sync (btn_sync),
    .run_cnt  (run_cnt),
    .mr_req   (mr_req)
);

// File: tb/test_mr_debounce.sv
// Bench for mr_debounce: a behavioural reference compared every cycle,
// plus directed checks at the window edges.
module test_mr_debounce;
    localparam int PRESS = 4;
    localparam int REL   = 4;
    localparam int DIV   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick;
    logic btn_n_raw = 1'b1;
    logic mr_req;

    logic auto_tick = 1'b1;
    logic man_tick = 1'b0;
    int   div_cnt = 0;
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    string phase = "R1";

    // reference model state
    int q[$] = '{1, 1};
    int m_cnt = 0;
    int m_req = 0;

    always #2.5 clk = ~clk;

    assign ms_tick = auto_tick ? (div_cnt == DIV - 1) : man_tick;

    mr_debounce #(.SYNC_STAGES(2), .PRESS_TICKS(PRESS), .RELEASE_TICKS(REL)) i_mr_debounce (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_n_raw(btn_n_raw), .mr_req(mr_req)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        int samp;
        int lim;
        if (!rst_n) begin
            q = '{1, 1};
            m_cnt = 0;
            m_req = 0;
        end else begin
            samp = q[0];
            void'(q.pop_front());
            q.push_back(int'(btn_n_raw));
            lim = m_req ? REL : PRESS;
            if (samp != m_req) m_cnt = 0;
            else if (ms_tick) begin
                m_cnt++;
                if (m_cnt >= lim) begin
                    m_req = 1 - m_req;
                    m_cnt = 0;
                end
            end
        end
    end

    // compare against the reference and advance the tick divider
    always @(negedge clk) begin
        cycles++;
        checks++;
        if (int'(mr_req) != m_req) begin
            errors++;
            $display("FAIL %s: per-cycle mr_req=%0d expected %0d at cycle %0d", phase, mr_req, m_req, cycles);
        end
        div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: mr_req=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick1();
        man_tick = 1'b1;
        @(negedge clk);
        man_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        wait_cycles(5);
        check("R1", mr_req, 1'b0);
        rst_n = 1'b1;
        wait_cycles(3);
        check("R1", mr_req, 1'b0);

        // R2: glitch shorter than one tick period
        phase = "R2";
        btn_n_raw = 1'b0; wait_cycles(6);
        btn_n_raw = 1'b1; wait_cycles(80);
        check("R2", mr_req, 1'b0);

        // R3: a long press is accepted
        phase = "R3";
        btn_n_raw = 1'b0; wait_cycles(80);
        check("R3", mr_req, 1'b1);
        // R5: request holds while pressed
        phase = "R5";
        wait_cycles(150);
        check("R5", mr_req, 1'b1);

        // R6: release bounce restarts the release count
        phase = "R6";
        btn_n_raw = 1'b1; wait_cycles(25);
        btn_n_raw = 1'b0; wait_cycles(3);
        btn_n_raw = 1'b1; wait_cycles(25);
        check("R6", mr_req, 1'b1);
        wait_cycles(60);
        check("R6", mr_req, 1'b0);

        // R4: a split press is not accepted
        phase = "R4";
        btn_n_raw = 1'b0; wait_cycles(25);
        btn_n_raw = 1'b1; wait_cycles(5);
        btn_n_raw = 1'b0; wait_cycles(25);
        btn_n_raw = 1'b1; wait_cycles(60);
        check("R4", mr_req, 1'b0);

        // R7: no ticks, no progress
        phase = "R7";
        auto_tick = 1'b0;
        btn_n_raw = 1'b0; wait_cycles(200);
        check("R7", mr_req, 1'b0);

        // R3: exact tick of acceptance with hand-driven ticks
        phase = "R3";
        tick1(); tick1(); tick1();
        check("R3", mr_req, 1'b0);
        tick1();
        check("R3", mr_req, 1'b1);

        // R6: exact tick of release, two edges after the input rises
        phase = "R6";
        btn_n_raw = 1'b1; wait_cycles(3);
        tick1(); tick1(); tick1();
        check("R6", mr_req, 1'b1);
        tick1();
        check("R6", mr_req, 1'b0);

        // R1: reset while pressed clears the request
        phase = "R1";
        btn_n_raw = 1'b0; wait_cycles(3);
        tick1(); tick1(); tick1(); tick1();
        check("R1", mr_req, 1'b1);
        rst_n = 1'b0; wait_cycles(2);
        check("R1", mr_req, 1'b0);
        rst_n = 1'b1; btn_n_raw = 1'b1; wait_cycles(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule